// File: doc/BRIEF.md
# Single-Bit Boolean Unit

This block performs single-bit Boolean work on a byte operand. One bit of the operand is picked by an index. The selected bit can be forced high, forced low, toggled or tested. It can also be moved into the carry flag, written from the carry flag, or merged into carry by AND, OR or XOR. Each transfer and merge also has a form that uses the complement. A processor datapath uses it with carry acting as a one-bit accumulator, so chains of bit tests reduce to a single flag.

The caller supplies the operand byte, the index, an operation code, and the present C and Z flags, and raises `in_valid`. One clock later the block returns the following registered values:
- the resulting byte,
- a write-back strobe that is set only for operations which modify the operand,
- the updated C and Z flags.

The caller handles fetching the operand and storing it back.

Top module: `bool_bit_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `res_byte`, `wr_en`, `c_out`, `z_out` and `out_valid` are all 0.
- R2: A vector presented with `in_valid`=1 produces its results, with `out_valid`=1, at the next rising clock edge. A cycle with `in_valid`=0 gives `out_valid`=0 and `wr_en`=0 at the next edge.
- R3: The selected bit position is `bit_idx[2:0]`. Bit 3 of `bit_idx` has no effect on any output.
- R4: Code 0 sets the selected bit, code 1 clears it and code 2 inverts it. Each returns the modified byte with `wr_en`=1, and leaves C and Z unchanged.
- R5: Code 3 (test) sets `z_out` to the complement of the selected bit. `c_out` equals `c_in` and `wr_en`=0.
- R6: Code 4 copies the selected bit into `c_out`. Code 5 copies its complement. For both, `z_out` equals `z_in` and `wr_en`=0.
- R7: Code 6 writes `c_in` into the selected bit and code 7 writes `~c_in`. For both, `wr_en`=1, the flags are unchanged, and no other bit of the byte changes.
- R8: Codes 8 to 13 set `c_out` to the result of a bit operation with `c_in`, leave `z_out` equal to `z_in`, and give `wr_en`=0. The operations are:
  - 8: bit AND C
  - 9: ~bit AND C
  - 10: bit OR C
  - 11: ~bit OR C
  - 12: bit XOR C
  - 13: ~bit XOR C
- R9: For every code that does not write back, `res_byte` equals the input operand unchanged.
- R10: Codes 14 and 15 are no-operations. They give `wr_en`=0, `res_byte` equal to the operand, `c_out`=`c_in` and `z_out`=`z_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Vector on the inputs is to be processed |
| op | input | 4 | Operation code (0 to 15) |
| bit_idx | input | IDX_IN_W (4) | Bit index; only the low 3 bits are used |
| operand | input | DATA_W (8) | Operand byte |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| res_byte | output | DATA_W (8) | Resulting byte |
| wr_en | output | 1 | Result must be written back to the destination |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |
| out_valid | output | 1 | Outputs hold the result of the previous accepted vector |

## Verification
The assertions assume that every input is a known 0 or 1 whenever `in_valid` is high. They also assume `in_valid` stays low while `rst` is high, so that values compared through `$past` always come from accepted vectors. The stimulus drives every input on the falling clock edge and keeps `in_valid` low through reset. It then sweeps all sixteen operation codes and all sixteen index values, including the upper half whose top bit must be ignored. Each combination is run against a set of operand patterns and all four flag combinations.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
package bitop_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    BOP_SET   = 4'd0,
    BOP_CLR   = 4'd1,
    BOP_INV   = 4'd2,
    BOP_TST   = 4'd3,
    BOP_LDC   = 4'd4,
    BOP_LDNC  = 4'd5,
    BOP_STC   = 4'd6,
    BOP_STNC  = 4'd7,
    BOP_ANDC  = 4'd8,
    BOP_ANDNC = 4'd9,
    BOP_ORC   = 4'd10,
    BOP_ORNC  = 4'd11,
    BOP_XORC  = 4'd12,
    BOP_XORNC = 4'd13,
    BOP_RSV0  = 4'd14,
    BOP_RSV1  = 4'd15
  } bop_e;

  // Read-modify-write class: the byte goes back to the destination.
  function automatic logic bop_writes(input bop_e o);
    return (o == BOP_SET) || (o == BOP_CLR) || (o == BOP_INV) ||
           (o == BOP_STC) || (o == BOP_STNC);
  endfunction
endpackage

// File: rtl/bit_mask_dec.sv
`timescale 1ns/1ps
module bit_mask_dec #(
  parameter int DATA_W = 8,
  localparam int SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/bit_eval.sv
`timescale 1ns/1ps
module bit_eval
  import bitop_pkg::*;
(
  input  bop_e op,
  input  logic sel_bit,
  input  logic c_in,
  input  logic z_in,
  output logic new_bit,
  output logic c_nx,
  output logic z_nx,
  output logic wr
);
  always_comb begin
    new_bit = sel_bit;
    c_nx    = c_in;
    z_nx    = z_in;
    wr      = bop_writes(op);
    unique case (op)
      BOP_SET:   new_bit = 1'b1;
      BOP_CLR:   new_bit = 1'b0;
      BOP_INV:   new_bit = ~sel_bit;
      BOP_TST:   z_nx    = ~sel_bit;
      BOP_LDC:   c_nx    = sel_bit;
      BOP_LDNC:  c_nx    = ~sel_bit;
      BOP_STC:   new_bit = c_in;
      BOP_STNC:  new_bit = ~c_in;
      BOP_ANDC:  c_nx    = sel_bit & c_in;
      BOP_ANDNC: c_nx    = ~sel_bit & c_in;
      BOP_ORC:   c_nx    = sel_bit | c_in;
      BOP_ORNC:  c_nx    = ~sel_bit | c_in;
      BOP_XORC:  c_nx    = sel_bit ^ c_in;
      BOP_XORNC: c_nx    = ~sel_bit ^ c_in;
      default: ;
    endcase
  end
endmodule

// File: rtl/bit_merge.sv
`timescale 1ns/1ps
module bit_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mask,
  input  logic              new_bit,
  output logic [DATA_W-1:0] merged,
  output logic              sel_bit
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_mux
    assign merged[i] = mask[i] ? new_bit : operand[i];
  end
  assign sel_bit = |(operand & mask);
endmodule

// File: rtl/bool_bit_unit.sv
`timescale 1ns/1ps
module bool_bit_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_IN_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     op,
  input  logic [IDX_IN_W-1:0] bit_idx,
  input  logic [DATA_W-1:0]   operand,
  input  logic                c_in,
  input  logic                z_in,
  output logic [DATA_W-1:0]   res_byte,
  output logic                wr_en,
  output logic                c_out,
  output logic                z_out,
  output logic                out_valid
);
  localparam int SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [SEL_W-1:0]  sel;
  logic              idx_unused;
  logic [DATA_W-1:0] mask, merged;
  logic              sel_bit, new_bit, c_nx, z_nx, wr;
  bop_e              op_q;

  assign sel        = bit_idx[SEL_W-1:0];
  assign idx_unused = ^bit_idx;
  assign op_q       = bop_e'(op);

  bit_mask_dec #(.DATA_W(DATA_W)) u_dec (.sel(sel), .mask(mask));

  bit_merge #(.DATA_W(DATA_W)) u_merge (
    .operand(operand), .mask(mask), .new_bit(new_bit),
    .merged(merged), .sel_bit(sel_bit)
  );

  bit_eval u_eval (
    .op(op_q), .sel_bit(sel_bit), .c_in(c_in), .z_in(z_in),
    .new_bit(new_bit), .c_nx(c_nx), .z_nx(z_nx), .wr(wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_byte  <= '0;
      wr_en     <= 1'b0;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & wr;
      if (in_valid) begin
        res_byte <= merged;
        c_out    <= c_nx;
        z_out    <= z_nx;
      end
    end
  end

  // R2: idle cycles produce neither valid nor write strobe
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en));

  // R4, R7: modifying codes raise the write strobe
  a_r4_write_class: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op <= 4'd2 || op == 4'd6 || op == 4'd7)) |=> wr_en);

  // R7: a write-back changes at most one bit of the operand
  a_r7_single_bit: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en) |-> ($countones(res_byte ^ $past(operand)) <= 1));

  // R9: read-only codes pass the operand through without a write
  a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd3 && op != 4'd6 && op != 4'd7)
      |=> (!wr_en && res_byte == $past(operand)));

  // R10: codes without flag effects leave C and Z untouched
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op <= 4'd2 || op == 4'd6 || op == 4'd7 || op >= 4'd14))
      |=> (c_out == $past(c_in) && z_out == $past(z_in)));

  // R5: test leaves carry alone
  a_r5_test_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd3) |=> (c_out == $past(c_in)));
endmodule

// File: tb/bool_bit_unit_test.sv
`timescale 1ns/1ps
module bool_bit_unit_test;
  logic       clk = 1'b0;
  logic       rst, in_valid, c_in, z_in;
  logic [3:0] op, bit_idx;
  logic [7:0] operand, res_byte;
  logic       wr_en, c_out, z_out, out_valid;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  bool_bit_unit #(.DATA_W(8), .IDX_IN_W(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .bit_idx(bit_idx),
    .operand(operand), .c_in(c_in), .z_in(z_in), .res_byte(res_byte),
    .wr_en(wr_en), .c_out(c_out), .z_out(z_out), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d idx=%0d opnd=%h c=%b z=%b)",
               req, act, exp, op, bit_idx, operand, c_in, z_in);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic string req_of(input int o, input int idx);
    if (idx >= 8) return "R3";
    if (o <= 2) return "R4";
    if (o == 3) return "R5";
    if (o <= 5) return "R6";
    if (o <= 7) return "R7";
    if (o <= 13) return "R8";
    return "R10";
  endfunction

  // Drive at a falling edge, check at the next falling edge (one register stage).
  task automatic run_vec(input int o, input int idx, input logic [7:0] d,
                         input logic c, input logic z);
    logic [7:0] eb, m;
    logic       b, ec, ez, ew;
    in_valid = 1'b1; op = 4'(o); bit_idx = 4'(idx);
    operand = d; c_in = c; z_in = z;
    m  = 8'h01 << (idx % 8);
    b  = (d & m) != 0;
    eb = d; ec = c; ez = z; ew = 1'b0;
    case (o)
      0: begin eb = d | m;  ew = 1'b1; end
      1: begin eb = d & ~m; ew = 1'b1; end
      2: begin eb = d ^ m;  ew = 1'b1; end
      3: ez = !b;
      4: ec = b;
      5: ec = !b;
      6: begin eb = c ? (d | m) : (d & ~m); ew = 1'b1; end
      7: begin eb = c ? (d & ~m) : (d | m); ew = 1'b1; end
      8: ec = b & c;
      9: ec = !b & c;
      10: ec = b | c;
      11: ec = !b | c;
      12: ec = b ^ c;
      13: ec = !b ^ c;
      default: ;
    endcase
    @(negedge clk);
    // R2 latency; R9 pass-through is covered by eb = d for read-only codes
    check(req_of(o, idx), {out_valid, wr_en, c_out, z_out, res_byte},
          {1'b1, ew, ec, ez, eb});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; bit_idx = '0;
    operand = '0; c_in = 1'b0; z_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, wr_en, c_out, z_out, res_byte}, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {out_valid, wr_en, c_out, z_out, res_byte}, 12'h000);

    for (int o = 0; o < 16; o++)
      for (int idx = 0; idx < 16; idx++)
        for (int k = 0; k < 6; k++)
          for (int f = 0; f < 4; f++) begin
            logic [7:0] d;
            case (k)
              0: d = 8'h00;
              1: d = 8'hFF;
              2: d = 8'hA5;
              3: d = 8'h5A;
              4: d = 8'(1 << (idx % 8));
              default: d = ~8'(1 << (idx % 8));
            endcase
            run_vec(o, idx, d, f[0], f[1]);
          end

    // R2: an idle cycle drops the valid and the write strobe
    run_vec(0, 5, 8'h00, 1'b1, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", {10'd0, out_valid, wr_en}, 12'd0);
    @(negedge clk);
    check("R2", {10'd0, out_valid, wr_en}, 12'd0);

    finish_run();
  end
endmodule